// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a restart window. A 12-bit down-counter moves one step on each pulse of a slow tick enable. Software must restart it before it runs out, and not too early. A restart is accepted as safe only once the counter has fallen to the programmed window delta or below. A restart made while the counter is still above the delta is counted as a window error. If the counter is allowed to pass zero, that is an underflow. Either fault sets a sticky status bit. Depending on the configuration, a fault also raises a fault interrupt and/or a one-cycle reset request. A separate level output says whether that request should reset only the processor or the whole system.

Configuration lives in a mode register that accepts a single write after reset and then locks. The register carries:
- the reload value and the window delta;
- a disable bit;
- interrupt-enable and reset-enable bits;
- a processor-only reset select;
- two halt bits. These freeze the counter while the idle input or the debug input is active.

A plain register port (write strobe, read strobe, 2-bit word address, 32-bit data) stands in for the system bus.

Top module: `wdog_window`

## Requirements
- R1: After reset, the mode register (address 1) reads 0x3FFF2FFF, the status register (address 2) reads 0, and both fault_irq and rst_req read 0. Address 0 is the control register.
- R2: Only the first write to the mode register after reset is taken. Bits [29:0] are stored and bits [31:30] read as 0. Every later write to the mode register is ignored. An accepted write also loads the counter with the new reload value.
- R3: While the counter runs, each tick decrements it by one. With reload value N in mode bits [11:0], the (N+1)-th tick after a reload is an underflow. The underflow sets status bit 0 and reloads the counter with N.
- R4: A restart is a write to the control register with 0xA5 in bits [31:24] and bit 0 set. It reloads the counter with the reload value. A control write with any other key, or with bit 0 clear, has no effect.
- R5: A restart while the counter is greater than the window delta (mode bits [27:16]) sets status bit 1. A restart while the counter is at or below the delta sets no status bit.
- R6: While disable (mode bit 15) is set, the counter does not move, no fault is raised, and restarts are ignored.
- R7: The counter is frozen while idle_in is high and idle-halt (mode bit 29) is set. It is also frozen while debug_in is high and debug-halt (mode bit 28) is set. With the matching halt bit clear, the input has no effect.
- R8: Status bits are sticky and are cleared by a read of the status register. A fault in the same cycle as the read wins over the clear.
- R9: fault_irq is high exactly while interrupt-enable (mode bit 12) is set and the status register is nonzero.
- R10: On each fault, when reset-enable (mode bit 13) is set, rst_req is high for exactly one cycle. rst_proc_only follows mode bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow tick enable, one clock cycle wide |
| idle_in | input | 1 | System idle indication |
| debug_in | input | 1 | Debugger halt indication |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a status read clears it) |
| reg_addr | input | 2 | Word address: 0 control, 1 mode, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fault_irq | output | 1 | Fault interrupt level |
| rst_req | output | 1 | One-cycle reset request on a fault |
| rst_proc_only | output | 1 | Reset request targets the processor only |

## Verification
The assertions check several rules on every cycle:
- each running tick moves the counter down by exactly one;
- the counter holds while a halt is active;
- a disabled watchdog never raises a fault;
- the mode register never changes once it is locked;
- a restart at or below the delta never flags a window error;
- the reset request never lasts past one cycle and only appears with reset-enable set.

The bench scenarios show the end-to-end behaviour that only appears at the register port. These are the exact tick count at which an underflow lands, where the window edge falls for several reload and delta pairs, that bad keys are rejected, that the mode register locks, clear-on-read, and the interrupt and reset-request outputs after a full fault sequence.

// File: rtl/wdw_pkg.sv
// Package: shared constants, field positions and the mode decode for the
// windowed watchdog. Assumes a 12-bit counter and a 30-bit mode register.
package wdw_pkg;
    localparam int CNT_W     = 12;
    localparam int MODE_W    = 30;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int KEY_W     = 8;
    localparam int KEY_LSB   = DATA_W - KEY_W;
    localparam int STAT_W    = 2;

    localparam int RLD_LSB   = 0;
    localparam int DLT_LSB   = 16;
    localparam int FIE_BIT   = 12;
    localparam int RSTEN_BIT = 13;
    localparam int PROC_BIT  = 14;
    localparam int DIS_BIT   = 15;
    localparam int DBG_BIT   = 28;
    localparam int IDLE_BIT  = 29;
    localparam int RESTART_BIT = 0;

    localparam logic [MODE_W-1:0] MODE_RESET = 30'h3FFF_2FFF;
    localparam logic [KEY_W-1:0]  RESTART_KEY = 8'hA5;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_STAT = 2'd2
    } wdw_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic             irq_en;
        logic             rst_en;
        logic             proc_only;
        logic             disable_wd;
        logic             dbg_halt;
        logic             idle_halt;
    } wdw_cfg_t;

    // Splits a raw mode word into named fields.
    function automatic wdw_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        wdw_cfg_t c;
        c.reload     = m[RLD_LSB +: CNT_W];
        c.delta      = m[DLT_LSB +: CNT_W];
        c.irq_en     = m[FIE_BIT];
        c.rst_en     = m[RSTEN_BIT];
        c.proc_only  = m[PROC_BIT];
        c.disable_wd = m[DIS_BIT];
        c.dbg_halt   = m[DBG_BIT];
        c.idle_halt  = m[IDLE_BIT];
        return c;
    endfunction
endpackage

// File: rtl/wdw_mode_reg.sv
// Write-once mode register. The first write after reset is stored and the
// register locks. Assumes wr_en is already decoded for the mode address.
module wdw_mode_reg #(
    parameter int MODE_W = wdw_pkg::MODE_W,
    parameter logic [MODE_W-1:0] RESET_VAL = wdw_pkg::MODE_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              locked_q,
    output logic              load_o
);
    // Accepted write: the first one since reset.
    always_comb load_o = wr_en && !locked_q;

    // Stores the mode word once and sets the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RESET_VAL;
            locked_q <= 1'b0;
        end else if (load_o) begin
            mode_q   <= wdata;
            locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wdw_counter.sv
// Down-counter with restart window. It decrements on tick while running,
// flags underflow at zero and flags a window error on early restarts.
// Assumes that tick is a single-cycle enable.
module wdw_counter #(
    parameter int CNT_W = wdw_pkg::CNT_W,
    parameter logic [CNT_W-1:0] RESET_CNT = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle_in,
    input  logic             debug_in,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] delta,
    input  logic             disable_wd,
    input  logic             idle_halt,
    input  logic             dbg_halt,
    input  logic             restart_req,
    input  logic             mode_load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_o,
    output logic             restart_ok_o,
    output logic             unf_evt_o,
    output logic             win_evt_o
);
    logic frozen;

    // A halt input freezes the counter only when its halt bit is set.
    always_comb frozen = (idle_halt && idle_in) || (dbg_halt && debug_in);

    // The counter runs when it is enabled and not frozen.
    always_comb run_o = !disable_wd && !frozen;

    // A restart counts only while the watchdog is enabled.
    always_comb restart_ok_o = restart_req && !disable_wd && !mode_load;

    // An early restart is a window error.
    always_comb win_evt_o = restart_ok_o && (cnt_q > delta);

    // Underflow: a running tick at zero with no reload in the same cycle.
    always_comb unf_evt_o = run_o && tick && (cnt_q == '0)
                            && !restart_ok_o && !mode_load;

    // Counter update. Priority: mode load, then restart, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_CNT;
        end else if (mode_load) begin
            cnt_q <= load_val;
        end else if (restart_ok_o) begin
            cnt_q <= reload;
        end else if (run_o && tick) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdw_status.sv
// Sticky fault status with clear-on-read, the interrupt level and the
// one-cycle reset request. Assumes that the event inputs are single-cycle.
module wdw_status #(
    parameter int STAT_W = wdw_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unf_evt,
    input  logic              win_evt,
    input  logic              rd_clr,
    input  logic              irq_en,
    input  logic              rst_en,
    output logic [STAT_W-1:0] status_q,
    output logic              irq_o,
    output logic              rst_pulse_q
);
    logic [STAT_W-1:0] set_vec;

    // Status bit 0 is underflow, bit 1 is window error.
    always_comb set_vec = {win_evt, unf_evt};

    // Sticky bits. A new event wins over a clear by read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (rd_clr ? '0 : status_q) | set_vec;
        end
    end

    // One-cycle reset request for each fault when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= rst_en && (|set_vec);
        end
    end

    // Interrupt level while enabled and any status bit is set.
    always_comb irq_o = irq_en && (|status_q);
endmodule

// File: rtl/wdog_window.sv
// Top of the windowed watchdog. It decodes the register port, holds the
// write-once mode register, the down-counter and the status logic.
// Assumes single-cycle read and write strobes on the register port.
module wdog_window #(
    parameter int DATA_W = wdw_pkg::DATA_W,
    parameter int ADDR_W = wdw_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              idle_in,
    input  logic              debug_in,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fault_irq,
    output logic              rst_req,
    output logic              rst_proc_only
);
    import wdw_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic              locked_q;
    logic              mode_load;
    wdw_cfg_t          cfg;
    logic [CNT_W-1:0]  cnt_q;
    logic              run;
    logic              restart_ok;
    logic              unf_evt;
    logic              win_evt;
    logic [STAT_W-1:0] status_q;
    logic              restart_req;
    logic              mode_we;
    logic              rd_clr;

    // Port decode for control, mode and status accesses.
    always_comb begin
        mode_we     = reg_we && (reg_addr == ADDR_MODE);
        restart_req = reg_we && (reg_addr == ADDR_CTRL)
                      && (reg_wdata[KEY_LSB +: KEY_W] == RESTART_KEY)
                      && reg_wdata[RESTART_BIT];
        rd_clr      = reg_re && (reg_addr == ADDR_STAT);
    end

    // Named view of the mode fields.
    always_comb cfg = decode_mode(mode_q);

    wdw_mode_reg #(.MODE_W(MODE_W), .RESET_VAL(MODE_RESET)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_we),
        .wdata    (reg_wdata[MODE_W-1:0]),
        .mode_q   (mode_q),
        .locked_q (locked_q),
        .load_o   (mode_load)
    );

    wdw_counter #(.CNT_W(CNT_W), .RESET_CNT(MODE_RESET[RLD_LSB +: CNT_W])) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .idle_in      (idle_in),
        .debug_in     (debug_in),
        .reload       (cfg.reload),
        .delta        (cfg.delta),
        .disable_wd   (cfg.disable_wd),
        .idle_halt    (cfg.idle_halt),
        .dbg_halt     (cfg.dbg_halt),
        .restart_req  (restart_req),
        .mode_load    (mode_load),
        .load_val     (reg_wdata[RLD_LSB +: CNT_W]),
        .cnt_q        (cnt_q),
        .run_o        (run),
        .restart_ok_o (restart_ok),
        .unf_evt_o    (unf_evt),
        .win_evt_o    (win_evt)
    );

    wdw_status #(.STAT_W(STAT_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .unf_evt     (unf_evt),
        .win_evt     (win_evt),
        .rd_clr      (rd_clr),
        .irq_en      (cfg.irq_en),
        .rst_en      (cfg.rst_en),
        .status_q    (status_q),
        .irq_o       (fault_irq),
        .rst_pulse_q (rst_req)
    );

    // Read mux. Unmapped addresses read as zero.
    always_comb begin
        case (reg_addr)
            ADDR_MODE: reg_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
            ADDR_STAT: reg_rdata = {{(DATA_W-STAT_W){1'b0}}, status_q};
            default:   reg_rdata = '0;
        endcase
    end

    // Reset scope select follows the mode bit.
    always_comb rst_proc_only = cfg.proc_only;
endmodule

// File: rtl/wdog_window_chk.sv
// Checker for wdog_window, attached with bind. It observes the counter,
// the mode lock, the fault events and the outputs.
module wdog_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        idle_in,
    input logic        debug_in,
    input logic [29:0] mode_q,
    input logic        locked_q,
    input logic        mode_load,
    input logic [11:0] cnt_q,
    input logic        run,
    input logic        restart_ok,
    input logic        unf_evt,
    input logic        win_evt,
    input logic [1:0]  status_q,
    input logic        rd_clr,
    input logic        fault_irq,
    input logic        rst_req
);
    import wdw_pkg::*;
    wdw_cfg_t c;
    always_comb c = decode_mode(mode_q);

    // R2: a locked mode register never changes.
    p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R3: a running tick above zero moves the counter down by one.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !restart_ok && !mode_load && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 12'd1));

    // R5: a restart at or below the delta is never a window error.
    p_window_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_ok && cnt_q <= c.delta) |-> !win_evt);

    // R6: a disabled watchdog raises no fault.
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c.disable_wd |-> !(unf_evt || win_evt));

    // R7: an active halt holds the counter.
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((c.idle_halt && idle_in) || (c.dbg_halt && debug_in))
         && !restart_ok && !mode_load) |=> $stable(cnt_q));

    // R8: a status read with no new fault leaves the status clear.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !unf_evt && !win_evt) |=> (status_q == 2'b00));

    // R9: the interrupt rises only after a fault or a mode load.
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_irq) |-> ($past(unf_evt || win_evt) || $past(mode_load)));

    // R10: the reset request lasts one cycle unless faults are back to back.
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !unf_evt && !win_evt) |=> !rst_req);

    // R10: the reset request needs reset-enable.
    p_pulse_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(c.rst_en));
endmodule

bind wdog_window wdog_window_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .idle_in    (idle_in),
    .debug_in   (debug_in),
    .mode_q     (mode_q),
    .locked_q   (locked_q),
    .mode_load  (mode_load),
    .cnt_q      (cnt_q),
    .run        (run),
    .restart_ok (restart_ok),
    .unf_evt    (unf_evt),
    .win_evt    (win_evt),
    .status_q   (status_q),
    .rd_clr     (rd_clr),
    .fault_irq  (fault_irq),
    .rst_req    (rst_req)
);

// File: tb/wdog_window_tb.sv
// Self-checking bench: a window vector table followed by directed tests.
module wdog_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        idle_in = 1'b0;
    logic        debug_in = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fault_irq;
    logic        rst_req;
    logic        rst_proc_only;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int cycles = 0;

    localparam logic [31:0] GOOD_RESTART = 32'hA500_0001;

    typedef struct packed {
        logic [31:0] mode;
        logic [7:0]  ticks;
        logic [1:0]  exp;
    } vec_t;

    // Mode word, ticks before restart, expected status after restart.
    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0003_2005, 8'd0,  2'd2},
        '{32'h0003_2005, 8'd1,  2'd2},
        '{32'h0003_2005, 8'd2,  2'd0},
        '{32'h0003_2005, 8'd5,  2'd0},
        '{32'h0003_2005, 8'd6,  2'd3},
        '{32'h0005_2005, 8'd0,  2'd0},
        '{32'h0000_200A, 8'd9,  2'd2},
        '{32'h0000_200A, 8'd10, 2'd0}
    };

    wdog_window u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .idle_in       (idle_in),
        .debug_in      (debug_in),
        .reg_we        (reg_we),
        .reg_re        (reg_re),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .fault_irq     (fault_irq),
        .rst_req       (rst_req),
        .rst_proc_only (rst_proc_only)
    );

    always #10 clk = ~clk;

    // Counts cycles with the reset request high.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_req) pulses <= pulses + 1;
    end

    // Ends a hung run as a failure.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle_in = 1'b0; debug_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    logic [31:0] d;

    initial begin
        // Window table: R3 and R5 (with R4 for a good restart).
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            wr(2'd1, VEC[v].mode);
            ticks(int'(VEC[v].ticks));
            wr(2'd0, GOOD_RESTART);
            rd(2'd2, d);
            check("R5 window table", d, {30'd0, VEC[v].exp});
        end

        // R1 reset state
        do_reset();
        #1;
        check("R1 irq at reset", {31'd0, fault_irq}, 32'd0);
        check("R1 rst_req at reset", {31'd0, rst_req}, 32'd0);
        rd(2'd1, d); check("R1 mode reset value", d, 32'h3FFF_2FFF);
        rd(2'd2, d); check("R1 status reset value", d, 32'd0);

        // R2 write-once mode register
        wr(2'd1, 32'hD234_5678);
        rd(2'd1, d); check("R2 first write taken", d, 32'h1234_5678);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); check("R2 second write ignored", d, 32'h1234_5678);

        // R4 bad key and missing restart bit are ignored
        do_reset();
        wr(2'd1, 32'h0003_2005);
        wr(2'd0, 32'h5A00_0001);
        rd(2'd2, d); check("R4 wrong key ignored", d, 32'd0);
        wr(2'd0, 32'hA500_0000);
        rd(2'd2, d); check("R4 no restart bit ignored", d, 32'd0);
        wr(2'd0, GOOD_RESTART);
        rd(2'd2, d); check("R4 keyed restart seen", d, 32'd2);

        // R3 underflow, reload and repeat; R8 clear on read
        do_reset();
        wr(2'd1, 32'h0003_0003);
        ticks(3);
        rd(2'd2, d); check("R3 no underflow before N+1 ticks", d, 32'd0);
        ticks(1);
        rd(2'd2, d); check("R3 underflow at N+1 ticks", d, 32'd1);
        rd(2'd2, d); check("R8 status cleared by read", d, 32'd0);
        ticks(3);
        rd(2'd2, d); check("R3 reloaded after underflow", d, 32'd0);
        ticks(1);
        rd(2'd2, d); check("R3 second underflow", d, 32'd1);

        // R6 disabled watchdog
        do_reset();
        wr(2'd1, 32'h0000_8002);
        ticks(10);
        rd(2'd2, d); check("R6 no underflow when disabled", d, 32'd0);
        wr(2'd0, GOOD_RESTART);
        rd(2'd2, d); check("R6 restart ignored when disabled", d, 32'd0);

        // R7 idle and debug halts
        do_reset();
        wr(2'd1, 32'h2003_0003);
        idle_in = 1'b1;
        ticks(10);
        rd(2'd2, d); check("R7 idle halt freezes", d, 32'd0);
        idle_in = 1'b0;
        ticks(4);
        rd(2'd2, d); check("R7 runs after idle ends", d, 32'd1);
        do_reset();
        wr(2'd1, 32'h1003_0003);
        debug_in = 1'b1;
        ticks(10);
        rd(2'd2, d); check("R7 debug halt freezes", d, 32'd0);
        do_reset();
        wr(2'd1, 32'h0003_0003);
        debug_in = 1'b1; idle_in = 1'b1;
        ticks(4);
        rd(2'd2, d); check("R7 halt inputs ignored with bits clear", d, 32'd1);

        // R9 interrupt level
        do_reset();
        wr(2'd1, 32'h0000_1001);
        ticks(2);
        #1 check("R9 irq on fault", {31'd0, fault_irq}, 32'd1);
        rd(2'd2, d);
        #1 check("R9 irq drops after read", {31'd0, fault_irq}, 32'd0);
        do_reset();
        wr(2'd1, 32'h0000_0001);
        ticks(2);
        #1 check("R9 no irq when disabled", {31'd0, fault_irq}, 32'd0);

        // R10 reset request pulse and scope
        do_reset();
        wr(2'd1, 32'h0000_6002);
        pulses = 0;
        ticks(3);
        repeat (2) @(negedge clk);
        check("R10 one pulse per fault", pulses, 32'd1);
        check("R10 proc-only select", {31'd0, rst_proc_only}, 32'd1);
        do_reset();
        wr(2'd1, 32'h0000_0002);
        pulses = 0;
        ticks(3);
        repeat (2) @(negedge clk);
        check("R10 no pulse without enable", pulses, 32'd0);
        rd(2'd2, d); check("R10 fault still recorded", d, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule